// File: doc/BRIEF.md
# RTC Serial Register Slave

This block is the always-on half of a real-time clock. A host reaches it over a four-wire bit-serial link (serial clock, frame enable, data in, data out). Behind the link sit a 32-bit seconds counter, a 32-bit seconds-adjust word and four 32-bit scratch words that keep their contents across host power cycles. A prescaler counts enable pulses from a 32.768 kHz reference and steps the seconds counter once per full count.

The link lines are sampled in the block's own clock domain through a configurable synchronizer, and edges on the serial clock are found there. The host waits for the ready output before it opens a frame. A write frame carries the data word first and the register address after it, both most-significant bit first. A read frame carries only the address. In both cases one direction bit, clocked after the enable has dropped, chooses commit or readout. A readout then returns one data bit per further serial clock pulse.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset `ready` is 1, `ser_dout` is 0 and every register reads back as zero.
- R2: A write frame is: `ser_en` high, 32 data bits then 3 address bits, each taken on a rising `ser_clk` edge and sent MSB first, `ser_en` low, then one direction bit of value 1. It stores the data in the addressed register.
- R3: A read frame is: `ser_en` high, 3 address bits MSB first, `ser_en` low, then one direction bit of value 0. After each of the next 32 rising `ser_clk` edges, `ser_dout` shows the next bit of the addressed register, MSB first. The last bit stays on `ser_dout` until the next frame opens.
- R4: Address 0 is the seconds counter, address 2 is the adjust word and addresses 4 to 7 are the scratch words. Writes to addresses 1 and 3 change nothing, and reads from them return zero.
- R5: The seconds counter rises by exactly one on the `PRESCALE`-th `ref_tick` pulse after its last step or load, and wraps from all-ones to zero.
- R6: A write to the seconds counter loads the written value and restarts the prescaler. The next step then needs a full `PRESCALE` pulses.
- R7: A frame whose bit count before the direction bit does not fit its direction (35 bits for 1, 3 bits for 0) is discarded. No register changes and no readout starts.
- R8: `ready` is 0 from the opening of a frame until the write commits, the frame is discarded or the 32nd readout bit has been shifted. Otherwise it is 1.
- R9: Asserting `rst_n` in the middle of a frame returns the block to idle with `ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en | input | 1 | Frame enable from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial readout data to the host |
| ready | output | 1 | High when the link is idle and a frame may start |

## Verification
The assertions assume that `ref_tick` is already a single-cycle enable in the `clk` domain. They also assume that the host changes only one link line at a time and holds each level for several block clocks, longer than the synchronizer depth. That lets every serial edge be seen once and lets enable edges and clock edges be told apart. The bench drives every line change on a falling `clk` edge and holds it for six cycles. It changes data only while the serial clock is low and pulses `ref_tick` only between frames. As a result, the counter value any readout returns can be worked out from the number of pulses applied.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
   // Address space is fixed: neighbours decode these positions.
   localparam int RTC_ADDR_W  = 3;
   localparam int RTC_NUM_SCR = 4;

   localparam logic [RTC_ADDR_W-1:0] A_SECS = 3'd0;
   localparam logic [RTC_ADDR_W-1:0] A_ADJ  = 3'd2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_DIR   = 2'd2,
      ST_READ  = 2'd3
   } ser_state_e;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768,
   localparam int PRE_W   = $clog2(PRESCALE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic             clear,
   output logic             wrap,
   output logic [PRE_W-1:0] count
);
   localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

   assign wrap = tick_in && (count == LAST) && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (clear)   count <= '0;
      else if (wrap)    count <= '0;
      else if (tick_in) count <= count + PRE_W'(1);
   end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_ser_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [RTC_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  sec_step,
   input  logic [RTC_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic [DATA_W-1:0]     secs_q
);
   logic [DATA_W-1:0] adj_q;
   logic [RTC_NUM_SCR-1:0][DATA_W-1:0] scr_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          secs_q <= '0;
      else if (wr_en && wr_addr == A_SECS) secs_q <= wr_data;
      else if (sec_step)                   secs_q <= secs_q + DATA_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         adj_q <= '0;
      else if (wr_en && wr_addr == A_ADJ) adj_q <= wr_data;
   end

   generate
      for (genvar g = 0; g < RTC_NUM_SCR; g++) begin : g_scr
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else if (wr_en && wr_addr == RTC_ADDR_W'(RTC_NUM_SCR + g)) word_q <= wr_data;
         end
         assign scr_bus[g] = word_q;
      end
   endgenerate

   always_comb begin
      if (rd_addr[RTC_ADDR_W-1])  rd_data = scr_bus[rd_addr[1:0]];
      else if (rd_addr == A_SECS) rd_data = secs_q;
      else if (rd_addr == A_ADJ)  rd_data = adj_q;
      else                        rd_data = '0;
   end
endmodule

// File: rtl/rtc_ser_engine.sv
module rtc_ser_engine
   import rtc_ser_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s_clk,
   input  logic                  s_en,
   input  logic                  s_din,
   input  logic [DATA_W-1:0]     rd_data,
   output logic [RTC_ADDR_W-1:0] rd_addr,
   output logic                  wr_en,
   output logic [RTC_ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0]     wr_data,
   output logic                  dout,
   output logic                  ready
);
   localparam int FRAME_W = DATA_W + RTC_ADDR_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   ser_state_e         state;
   logic               clk_q, en_q;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  out_sr;
   logic               rise, en_up, en_dn;

   assign rise    = s_clk & ~clk_q;
   assign en_up   = s_en & ~en_q;
   assign en_dn   = ~s_en & en_q;
   assign rd_addr = sr[RTC_ADDR_W-1:0];
   assign ready   = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         clk_q   <= 1'b0;
         en_q    <= 1'b0;
         sr      <= '0;
         cnt     <= '0;
         out_sr  <= '0;
         dout    <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         clk_q <= s_clk;
         en_q  <= s_en;
         wr_en <= 1'b0;
         if (en_up) begin
            state <= ST_SHIFT;
            cnt   <= '0;
            dout  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_SHIFT: begin
                  if (en_dn) begin
                     state <= ST_DIR;
                  end else if (rise) begin
                     sr <= {sr[FRAME_W-2:0], s_din};
                     if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_DIR: begin
                  if (rise) begin
                     if (s_din && cnt == CNT_W'(FRAME_W)) begin
                        wr_en   <= 1'b1;
                        wr_addr <= sr[RTC_ADDR_W-1:0];
                        wr_data <= sr[FRAME_W-1:RTC_ADDR_W];
                        state   <= ST_IDLE;
                     end else if (!s_din && cnt == CNT_W'(RTC_ADDR_W)) begin
                        out_sr <= rd_data;
                        cnt    <= '0;
                        state  <= ST_READ;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_READ: begin
                  if (rise) begin
                     dout   <= out_sr[DATA_W-1];
                     out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                     cnt    <= cnt + CNT_W'(1);
                     if (cnt == CNT_W'(DATA_W - 1)) state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
   import rtc_ser_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int PRESCALE    = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic ser_clk,
   input  logic ser_en,
   input  logic ser_din,
   output logic ser_dout,
   output logic ready
);
   localparam int PRE_W = $clog2(PRESCALE);

   generate
      if (DATA_W < 8)
         $error("rtc_serial_slave: DATA_W must be at least 8");
      if (PRESCALE < 2)
         $error("rtc_serial_slave: PRESCALE must be at least 2");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3)
         $error("rtc_serial_slave: SYNC_STAGES must be 0 to 3");
   endgenerate

   logic [2:0]            sync_q;
   logic                  wr_en, sec_load, sec_step;
   logic [RTC_ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0]     wr_data, rd_data, secs_q;
   logic [PRE_W-1:0]      pre_cnt;

   rtc_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_clk, ser_en, ser_din}), .q(sync_q)
   );

   rtc_ser_engine #(.DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .s_clk(sync_q[2]), .s_en(sync_q[1]), .s_din(sync_q[0]),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(ser_dout), .ready(ready)
   );

   assign sec_load = wr_en && (wr_addr == A_SECS);

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_in(ref_tick), .clear(sec_load),
      .wrap(sec_step), .count(pre_cnt)
   );

   rtc_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec_step(sec_step), .rd_addr(rd_addr), .rd_data(rd_data),
      .secs_q(secs_q)
   );
endmodule

// File: rtl/rtc_serial_checker.sv
module rtc_serial_checker #(
   parameter int DATA_W   = 32,
   parameter int PRESCALE = 32768,
   localparam int PRE_W   = $clog2(PRESCALE)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic              ready,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] secs_q,
   input logic [PRE_W-1:0]  pre_cnt
);
   logic load;
   assign load = wr_en && (wr_addr == 3'd0);

   // R5: prescaler never leaves its range
   a_r5_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= PRE_W'(PRESCALE - 1));

   // R5: without a load the counter holds or steps by one
   a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (secs_q == $past(secs_q)) || (secs_q == $past(secs_q) + DATA_W'(1)));

   // R5: the last reference pulse of a period steps the counter
   a_r5_wrap_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && pre_cnt == PRE_W'(PRESCALE - 1) && !load)
         |=> secs_q == $past(secs_q) + DATA_W'(1));

   // R6: a load takes the written value and restarts the prescaler
   a_r6_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pre_cnt == '0) && (secs_q == $past(wr_data)));

   // R8: a committing write leaves the link idle
   a_r8_commit_ready: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ready);
endmodule

bind rtc_serial_slave rtc_serial_checker #(.DATA_W(DATA_W), .PRESCALE(PRESCALE)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ready(ready),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .secs_q(secs_q), .pre_cnt(pre_cnt)
);

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
   localparam int TB_PRE = 8;
   localparam int HOLD   = 6;

   logic clk = 1'b0;
   logic rst_n, ref_tick, ser_clk, ser_en, ser_din;
   logic ser_dout, ready;

   int vectors = 0;
   int miscompares = 0;

   logic [31:0] mdl [8];
   int          mpre;

   always #2 clk = ~clk;

   rtc_serial_slave #(.DATA_W(32), .PRESCALE(TB_PRE), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
      .ser_dout(ser_dout), .ready(ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic half();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic pulse();
      ser_clk = 1'b0; half();
      ser_clk = 1'b1; half();
   endtask

   task automatic send_bit(input logic b);
      ser_clk = 1'b0;
      ser_din = b; half();
      pulse();
   endtask

   task automatic frame(input logic [34:0] bits, input int nb, input logic dirb,
                        input bit rd_out, output logic [31:0] rd);
      ser_clk = 1'b0; ser_din = 1'b0; half();
      ser_en = 1'b1; half();
      chk("R8 ready low after frame opens", {31'b0, ready}, 32'd0);
      for (int i = nb - 1; i >= 0; i--) send_bit(bits[i]);
      ser_en = 1'b0; half();
      send_bit(dirb);
      ser_din = 1'b0; half();
      rd = '0;
      if (rd_out) begin
         for (int i = 0; i < 32; i++) begin
            pulse();
            rd = {rd[30:0], ser_dout};
            if (i == 15) chk("R8 ready low during readout", {31'b0, ready}, 32'd0);
         end
      end
      half();
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      logic [31:0] junk;
      frame({d, a}, 35, 1'b1, 1'b0, junk);
      if (a != 3'd1 && a != 3'd3) mdl[a] = d;
      if (a == 3'd0) mpre = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a);
      logic [31:0] got;
      frame({32'b0, a}, 3, 1'b0, 1'b1, got);
      chk(tag, got, mdl[a]);
      chk("R8 ready back high after readout", {31'b0, ready}, 32'd1);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1; @(negedge clk);
         ref_tick = 1'b0; @(negedge clk);
         mpre++;
         if (mpre == TB_PRE) begin
            mpre = 0;
            mdl[0] = mdl[0] + 32'd1;
         end
      end
   endtask

   function automatic logic [31:0] pat(input int a, input int k);
      return ((a + 1) * 32'h9E37_79B9) ^ (k * 32'h0123_4567) ^ 32'h8000_0001;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] junk;
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      mpre = 0;
      rst_n = 1'b0; ref_tick = 1'b0;
      ser_clk = 1'b0; ser_en = 1'b0; ser_din = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1; half();

      // R1: reset state
      chk("R1 ready after reset", {31'b0, ready}, 32'd1);
      chk("R1 dout after reset", {31'b0, ser_dout}, 32'd0);
      for (int a = 0; a < 8; a++) rd_chk("R1 register zero after reset", 3'(a));

      // R2 R3 R4: write sweep over every address, then read back all
      for (int k = 0; k < 3; k++) begin
         for (int a = 0; a < 8; a++) wr(3'(a), pat(a, k));
         for (int a = 0; a < 8; a++) rd_chk("R2 R3 R4 readback after sweep", 3'(a));
      end
      chk("R4 address 1 reads zero", mdl[1], 32'd0);
      chk("R3 last bit held on dout", {31'b0, ser_dout}, {31'b0, mdl[7][0]});

      // R5: counter steps on the PRESCALE-th pulse and wraps
      wr(3'd0, 32'hFFFF_FFFE);
      tick(TB_PRE - 1);
      rd_chk("R5 no step before full period", 3'd0);
      tick(1);
      rd_chk("R5 step on last pulse", 3'd0);
      tick(TB_PRE);
      rd_chk("R5 wrap to zero", 3'd0);
      chk("R5 wrapped value", mdl[0], 32'd0);

      // R6: load restarts the prescaler
      tick(5);
      wr(3'd0, 32'd100);
      tick(TB_PRE - 1);
      rd_chk("R6 no step a pulse short after load", 3'd0);
      tick(1);
      rd_chk("R6 step after full period from load", 3'd0);

      // R7: malformed frames discarded
      frame({32'h1234_5678, 3'd5}, 34, 1'b1, 1'b0, junk);
      chk("R7 ready after short write", {31'b0, ready}, 32'd1);
      rd_chk("R7 short write leaves word", 3'd5);
      frame({32'h0, 3'd6}, 3, 1'b1, 1'b0, junk);
      rd_chk("R7 read-length frame with write bit", 3'd6);
      frame({32'hCAFE_F00D, 3'd4}, 35, 1'b0, 1'b0, junk);
      chk("R7 no readout on write-length frame", {31'b0, ready}, 32'd1);
      rd_chk("R7 write-length frame with read bit", 3'd4);
      frame({32'h0, 3'd2}, 4, 1'b0, 1'b0, junk);
      chk("R7 no readout on 4-bit read", {31'b0, ready}, 32'd1);
      rd_chk("R7 adjust word intact", 3'd2);

      // R9: reset in the middle of a frame
      ser_clk = 1'b0; ser_din = 1'b0; half();
      ser_en = 1'b1; half();
      for (int i = 0; i < 10; i++) send_bit(i[0]);
      chk("R9 ready low mid-frame", {31'b0, ready}, 32'd0);
      rst_n = 1'b0; half();
      ser_en = 1'b0; ser_clk = 1'b0;
      rst_n = 1'b1; half();
      chk("R9 ready after mid-frame reset", {31'b0, ready}, 32'd1);
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      mpre = 0;
      rd_chk("R9 scratch cleared by reset", 3'd6);
      wr(3'd7, 32'h5A5A_0FF0);
      rd_chk("R9 link usable after reset", 3'd7);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule